// File: doc/BRIEF.md
# Virtual-to-Physical Address Translation Unit

This block sits between a processor and a physically addressed cache. It takes a virtual address together with an access type and a privilege mode, and returns either a physical address or a fault code. The page offset passes through unchanged. The page number is looked up in a small fully associative translation buffer. Each slot of that buffer holds a whole page table entry, including its rights bits. When the lookup misses, a hardware walker reads one word from a single-level page table in memory. The word sits at the page table base plus four times the virtual page number. If the fetched entry is usable, the walker installs it in the buffer.

Every result is checked against the access rights of the entry, both after a hit and after a walk. A request for a page that is not resident returns a page fault. A request that the rights do not allow returns a protection fault. Entries that fault are never cached. A flush pulse invalidates the whole buffer in one cycle. Software pulses it after it changes the table base.

Requests and responses use valid/ready handshakes with one transaction in flight. A request is taken only while the unit is idle, so holding off `rsp_ready` stalls the next request. The walker's memory port is also valid/ready for the address. The read data returns on a single-cycle strobe that is always accepted.

Top module: `mmu_xlate`

## Requirements
- R1: `req_ready` is high only when no translation is in progress and no response is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: Once `rsp_valid` is high, it stays high and `rsp_paddr` and `rsp_fault` stay unchanged until a clock edge where `rsp_ready` is high.
- R3: On a response with fault code 0, `rsp_paddr` is the physical page number in bits 23..12 followed by the unchanged virtual offset in bits 11..0.
- R4: On a hit in the buffer, no memory read is issued, and `rsp_valid` rises on the second clock edge after the request is taken.
- R5: On a miss, exactly one memory read is issued, at `ptbr + vpn*4` (modulo 2^24), with `mem_req_valid` and `mem_addr` held until `mem_req_ready`.
- R6: A page table entry word has valid in bit 31, user-allowed in bit 30, read in bit 29, write in bit 28, execute in bit 27, and the physical page number in bits 11..0. A fetched entry with bit 31 at 0 returns fault code 1 (page fault) with `rsp_paddr` equal to 0.
- R7: Access kind 0 (read) needs the read bit, kind 1 (write) needs the write bit, kind 2 (fetch) needs the execute bit, and kind 3 is never allowed. A user-mode request also needs the user-allowed bit. A request that fails this check returns fault code 2 (protection fault) with `rsp_paddr` equal to 0. The check applies on hits and after walks.
- R8: An entry fetched by a walk is installed only if that walk returned fault code 0. A later access to an installed page hits. A page that faulted is walked again on every access.
- R9: The buffer has 8 slots, and installs go to slots in round-robin order starting at slot 0 after reset. The ninth distinct install evicts the first one, and the other seven still hit.
- R10: A one-cycle `flush` pulse invalidates every slot, so the next access to any previously cached page walks the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every buffer slot |
| ptbr | input | 24 | Physical base address of the page table |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_req_valid | output | 1 | Walker read request |
| mem_req_ready | input | 1 | Memory takes the read address |
| mem_addr | output | 24 | Address of the page table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Page table entry word |

## Verification
The hardest case to reach is the seven-way survival after an eviction. The buffer must hold eight distinct usable pages, then receive exactly one more install, and then be probed. Any faulting access in between would leave the buffer unchanged, and a stray hit would leave the round-robin pointer where it was. The directed part of the stimulus therefore uses a reserved page range whose entries always carry full rights. It installs nine pages there and probes the survivors. Protection faults on hits are reached the same way, through a read-only range that is first installed by a permitted read. The random phase draws addresses from a pool three times the buffer size. A salt in the bench's table model is changed together with a flush, so hits, walks, evictions, faults and back-pressure on both handshakes interleave.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } flt_e;

  // Rights bits as they sit next to each other in the table word.
  typedef struct packed {
    logic user_ok;
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  localparam int PTE_VALID_BIT = 31;
  localparam int PTE_RIGHTS_HI = 30;
  localparam int PTE_RIGHTS_LO = 27;

endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
  import mmu_pkg::*;
(
  input  rights_t rights,
  input  acc_e    kind,
  input  logic    user,
  output logic    ok
);
  logic kind_ok;

  always_comb begin
    unique case (kind)
      ACC_READ:  kind_ok = rights.rd;
      ACC_WRITE: kind_ok = rights.wr;
      ACC_FETCH: kind_ok = rights.ex;
      default:   kind_ok = 1'b0;
    endcase
    ok = kind_ok && (!user || rights.user_ok);
  end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import mmu_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  output rights_t            hit_rights,
  input  logic               ins_en,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PPN_W-1:0]   ins_ppn,
  input  rights_t            ins_rights
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  rights_t            rgt_q [ENTRIES];
  logic [IDX_W-1:0]   victim_q;

  wire do_ins = ins_en && !flush;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          tag_q[g] <= '0;
          ppn_q[g] <= '0;
          rgt_q[g] <= '0;
        end else if (flush) begin
          vld_q[g] <= 1'b0;
        end else if (do_ins && victim_q == IDX_W'(g)) begin
          vld_q[g] <= 1'b1;
          tag_q[g] <= ins_vpn;
          ppn_q[g] <= ins_ppn;
          rgt_q[g] <= ins_rights;
        end
      end
    end
  endgenerate

  // Tags are unique, so at most one slot matches: an OR of masked slots is the mux.
  always_comb begin
    hit_ppn    = '0;
    hit_rights = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn    = hit_ppn    | ({PPN_W{hit_vec[i]}} & ppn_q[i]);
      hit_rights = hit_rights | ({$bits(rights_t){hit_vec[i]}} & rgt_q[i]);
    end
    hit = |hit_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      victim_q <= '0;
    else if (do_ins)
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 24,
  parameter int OFF_W       = 12,
  parameter int TLB_ENTRIES = 8,
  parameter int PTE_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  ptbr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WREQ, S_WAIT, S_RESP} st_e;

  st_e              st_q;
  logic [VA_W-1:0]  va_q;
  acc_e             kind_q;
  logic             user_q;
  logic [PA_W-1:0]  pa_q;
  flt_e             flt_q;

  logic [VPN_W-1:0]       vpn;
  logic [OFF_W-1:0]       off;
  logic [TLB_ENTRIES-1:0] tlb_hit_vec;
  logic                   tlb_hit;
  logic [PPN_W-1:0]       tlb_ppn;
  rights_t                tlb_rights;

  logic             walk_vld;
  rights_t          walk_rights;
  logic [PPN_W-1:0] walk_ppn;
  rights_t          chk_rights;
  logic             perm_ok;
  logic             ins_en;
  logic [PTE_RIGHTS_LO-PPN_W-1:0] unused_pte_bits;

  assign vpn = va_q[VA_W-1:OFF_W];
  assign off = va_q[OFF_W-1:0];

  assign walk_vld        = mem_rsp_data[PTE_VALID_BIT];
  assign walk_rights     = rights_t'(mem_rsp_data[PTE_RIGHTS_HI:PTE_RIGHTS_LO]);
  assign walk_ppn        = mem_rsp_data[PPN_W-1:0];
  assign unused_pte_bits = mem_rsp_data[PTE_RIGHTS_LO-1:PPN_W];

  assign chk_rights = (st_q == S_WAIT) ? walk_rights : tlb_rights;
  assign ins_en     = (st_q == S_WAIT) && mem_rsp_valid && walk_vld && perm_ok;

  mmu_tlb #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ENTRIES(TLB_ENTRIES)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (vpn),
    .hit_vec   (tlb_hit_vec),
    .hit       (tlb_hit),
    .hit_ppn   (tlb_ppn),
    .hit_rights(tlb_rights),
    .ins_en    (ins_en),
    .ins_vpn   (vpn),
    .ins_ppn   (walk_ppn),
    .ins_rights(walk_rights)
  );

  mmu_perm u_perm (
    .rights(chk_rights),
    .kind  (kind_q),
    .user  (user_q),
    .ok    (perm_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      va_q   <= '0;
      kind_q <= ACC_READ;
      user_q <= 1'b0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= acc_e'(req_kind);
          user_q <= req_user;
          st_q   <= S_LOOK;
        end
        S_LOOK: if (tlb_hit) begin
          flt_q <= perm_ok ? FLT_NONE : FLT_PROT;
          pa_q  <= perm_ok ? {tlb_ppn, off} : '0;
          st_q  <= S_RESP;
        end else begin
          st_q <= S_WREQ;
        end
        S_WREQ: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!walk_vld) begin
            flt_q <= FLT_PAGE;
            pa_q  <= '0;
          end else begin
            flt_q <= perm_ok ? FLT_NONE : FLT_PROT;
            pa_q  <= perm_ok ? {walk_ppn, off} : '0;
          end
          st_q <= S_RESP;
        end
        S_RESP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == S_IDLE);
  assign rsp_valid     = (st_q == S_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = flt_q;
  assign mem_req_valid = (st_q == S_WREQ);
  assign mem_addr      = ptbr + (PA_W'(vpn) << 2);
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 24,
  parameter int OFF_W       = 12,
  parameter int TLB_ENTRIES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VA_W-1:0]        req_vaddr,
  input logic [PA_W-1:0]        ptbr,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [PA_W-1:0]        rsp_paddr,
  input logic [1:0]             rsp_fault,
  input logic                   mem_req_valid,
  input logic                   mem_req_ready,
  input logic [PA_W-1:0]        mem_addr,
  input logic [TLB_ENTRIES-1:0] tlb_hit_vec
);
  logic [VA_W-1:0] cap_va;

  always_ff @(posedge clk) begin
    if (!rst_n) cap_va <= '0;
    else if (req_valid && req_ready) cap_va <= req_vaddr;
  end

  assert_one_in_flight_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == cap_va[OFF_W-1:0]));

  assert_walk_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_addr == ptbr + (PA_W'(cap_va[VA_W-1:OFF_W]) << 2)));

  assert_walk_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3));

  assert_unique_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit_vec));
endmodule

bind mmu_xlate mmu_xlate_chk #(
  .VA_W       (VA_W),
  .PA_W       (PA_W),
  .OFF_W      (OFF_W),
  .TLB_ENTRIES(TLB_ENTRIES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .ptbr         (ptbr),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_addr     (mem_addr),
  .tlb_hit_vec  (tlb_hit_vec)
);

// File: tb/mmu_xlate_tb.sv
`timescale 1ns/1ps
module mmu_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [23:0] ptbr = 24'h040000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [23:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_cmp = 0, n_bad = 0, n_reads = 0;
  logic [23:0] last_addr = '0;
  logic [31:0] salt = 32'h1234_5678;
  logic [19:0] mtag [8];
  bit          mval [8];
  int          mptr = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  mmu_xlate u_dut (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Table contents: three fixed ranges for directed cases, hashed rights elsewhere.
  function automatic logic [31:0] gen_pte(input logic [19:0] vpn);
    logic [31:0] h;
    case (vpn[19:16])
      4'hF: return {5'b11111, 15'd0, vpn[11:0]};
      4'hE: return {5'b10100, 15'd0, vpn[11:0]};
      4'hD: return {5'b01111, 15'd0, vpn[11:0]};
      default: begin
        h = ({12'd0, vpn} ^ salt) * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        return {h[2:0] != 3'd0, h[5], h[6] | h[7], h[8], h[9], 15'd0, h[27:16]};
      end
    endcase
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] pte, input logic [1:0] kind, input logic user);
    logic ok;
    if (!pte[31]) return 2'd1;
    case (kind)
      2'd0: ok = pte[29];
      2'd1: ok = pte[28];
      2'd2: ok = pte[27];
      default: ok = 1'b0;
    endcase
    ok = ok && (!user || pte[30]);
    return ok ? 2'd0 : 2'd2;
  endfunction

  // Memory side: random address back-pressure and random read latency.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_data  = gen_pte(20'((last_addr - ptbr) >> 2));
        mem_rsp_valid = 1'b1;
      end else if (mem_req_valid && ($urandom % 3 != 0)) begin
        mem_req_ready = 1'b1;
        last_addr     = mem_addr;
        n_reads++;
      end
    end
  end

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind, input logic user,
                       input int stall, input string tag);
    logic [19:0] vpn;
    logic [31:0] pte;
    logic [23:0] ep, held, ea;
    logic [1:0]  ef;
    bit hit;
    int r0, lat;
    vpn = va[31:12];
    pte = gen_pte(vpn);
    hit = 0;
    for (int i = 0; i < 8; i++) if (mval[i] && mtag[i] == vpn) hit = 1;
    ef = exp_fault(pte, kind, user);
    ep = (ef == 2'd0) ? {pte[11:0], va[11:0]} : 24'h0;
    ea = ptbr + {2'b00, vpn, 2'b00};
    r0 = n_reads;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_user = user; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    if (hit) begin
      chk(tag, "hit latency", lat, 2);
      chk(tag, "reads on hit", n_reads - r0, 0);
    end else begin
      chk(tag, "reads on walk", n_reads - r0, 1);
      chk("R5", "walk address", last_addr, ea);
    end
    chk(ef == 2'd1 ? "R6" : (ef == 2'd2 ? "R7" : "R3"), "fault code", rsp_fault, ef);
    chk(ef == 2'd0 ? "R3" : "R7", "paddr", rsp_paddr, ep);
    held = rsp_paddr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R2", "valid held", rsp_valid, 1);
      chk("R2", "paddr held", rsp_paddr, held);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1", "ready after response", req_ready, 1);
    if (!hit && ef == 2'd0) begin
      mtag[mptr] = vpn; mval[mptr] = 1; mptr = (mptr + 1) % 8;
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 8; i++) mval[i] = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) begin mval[i] = 0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset req_ready", req_ready, 1);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset mem_req_valid", mem_req_valid, 0);

    // Install then hit (R4, R8).
    xlate({20'hF0001, 12'hABC}, 2'd0, 1'b0, 0, "R8");
    xlate({20'hF0001, 12'h123}, 2'd2, 1'b1, 3, "R4");
    // Eight more installs: the ninth overall evicts the first (R9).
    for (int k = 2; k <= 9; k++) xlate({20'hF0000 | 20'(k), 12'h010}, 2'd1, 1'b0, 0, "R9");
    for (int k = 2; k <= 9; k++) xlate({20'hF0000 | 20'(k), 12'h020}, 2'd0, 1'b0, 0, "R9");
    xlate({20'hF0001, 12'h030}, 2'd0, 1'b0, 0, "R9");
    // Rights on the read-only kernel range (R7).
    xlate({20'hE0005, 12'h444}, 2'd0, 1'b1, 0, "R7");
    xlate({20'hE0005, 12'h444}, 2'd0, 1'b0, 0, "R7");
    xlate({20'hE0005, 12'h445}, 2'd1, 1'b0, 1, "R7");
    xlate({20'hE0005, 12'h446}, 2'd2, 1'b0, 0, "R7");
    xlate({20'hE0005, 12'h447}, 2'd3, 1'b0, 0, "R7");
    // Non-resident page, never cached (R6, R8).
    xlate({20'hD0003, 12'h000}, 2'd0, 1'b0, 0, "R6");
    xlate({20'hD0003, 12'hFFF}, 2'd0, 1'b0, 2, "R8");
    // Flush forces walks (R10).
    do_flush();
    xlate({20'hF0002, 12'h777}, 2'd0, 1'b0, 0, "R10");
    xlate({20'hE0005, 12'h777}, 2'd0, 1'b0, 0, "R10");

    // Random mix over a page pool larger than the buffer.
    for (int t = 0; t < 450; t++) begin
      logic [19:0] v;
      if (t % 150 == 149) begin
        salt = salt ^ $urandom;
        do_flush();
      end
      case ($urandom % 8)
        0: v = 20'hF0000 | 20'($urandom % 4);
        1: v = 20'hE0000 | 20'($urandom % 2);
        2: v = 20'hD0000;
        default: v = 20'($urandom % 24);
      endcase
      xlate({v, 12'($urandom)}, 2'($urandom), 1'($urandom), int'($urandom % 3), "R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule